// File: doc/BRIEF.md
# Quadword SECDED Syndrome Classifier and Corrector

This block sits after the check-bit comparison stage of a memory read path. Each cycle it may accept an 8-bit syndrome and the 64-bit quadword that produced it. The quadword holds four 16-bit words. It sorts the syndrome into one of five outcomes: clean, a failed check bit, a correctable single data-bit upset, an odd-weight code that points at no data bit, or an uncorrectable multi-bit error.

When a single data bit has failed, the block names the failing word and the bit inside that word, and it returns the quadword with that bit inverted. In every other case the quadword passes through unchanged. The failing word comes from a small lookup on three syndrome bits. The bit number is the upper syndrome nibble read in reverse order. Both word and bit numbers count from the most significant end. All results are registered, so they appear one cycle after the input strobe.

Top module: `secded_quad_fix`

## Requirements
- R1: A synchronous active-high reset drives `res_valid` to 0 and `res_class` to 0 at the next rising edge.
- R2: `res_valid` equals the value `chk_valid` had at the previous rising edge. While `chk_valid` is low, all other result outputs keep their values.
- R3: A syndrome of 0 gives class 0 (none), and the data passes through unchanged.
- R4: A syndrome with exactly one set bit gives class 1 (check-bit error). `res_chk_idx` is 7 minus the set bit's position, so 0x01 (the overall parity bit) gives 7 and 0x80 gives 0. The data passes through unchanged.
- R5: A syndrome with odd weight, not one-hot, and syndrome bits [3:1] equal to 3, 5, 6 or 7 gives class 2 (single data-bit error). `res_word_idx` is 0, 1, 2 or 3 in that same order.
- R6: For class 2, `res_bit_idx` is syndrome bits [7:4] in reverse order: syndrome bit 4 is the index MSB and syndrome bit 7 is the index LSB. So 0001 gives 8 and 0010 gives 4.
- R7: For class 2, `res_data` is the input with exactly bit `63 - (16*word + bit)` inverted. Word 0 and bit 0 are the most significant.
- R8: An odd-weight, non-one-hot syndrome whose bits [3:1] are 0, 1, 2 or 4 gives class 3 (bad code), and the data passes through unchanged.
- R9: A nonzero even-weight syndrome gives class 4 (multiple error), and the data passes through unchanged.
- R10: `res_chk_idx` is 0 unless the class is 1. `res_word_idx` and `res_bit_idx` are 0 unless the class is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Syndrome and data are presented this cycle |
| chk_syn | input | 8 | Error-check syndrome |
| chk_data | input | 64 | Quadword as read, word 0 in bits 63:48 |
| res_valid | output | 1 | Results are valid |
| res_class | output | 3 | 0 none, 1 check bit, 2 single corrected, 3 bad code, 4 multiple |
| res_chk_idx | output | 3 | Failing check-bit number |
| res_word_idx | output | 2 | Failing word number |
| res_bit_idx | output | 4 | Failing bit number within the word |
| res_data | output | 64 | Corrected or passed-through quadword |

## Verification
Every one of the 256 syndrome values is applied under four data patterns: all zeros, all ones, an ascending nibble count, and a mixed checkerboard. Running all syndromes separates the five classes at every boundary between them: one-hot against odd weight, a valid word code against an invalid one, and even against odd weight. The differing data backgrounds show whether a correction flips exactly one bit in the right direction and leaves the rest untouched, instead of forcing the bit to a constant. Idle cycles check that the outputs hold, and a reset in the middle of the run checks that the result strobe clears.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_CHECK   = 3'd1,
      ERR_SINGLE  = 3'd2,
      ERR_BADCODE = 3'd3,
      ERR_MULTI   = 3'd4
   } err_class_e;

   localparam int CLASS_W     = 3;
   localparam int WORD_CODE_W = 3;

endpackage

// File: rtl/syn_classify.sv
module syn_classify
   import secded_pkg::*;
#(
   parameter int SYN_W     = 8,
   parameter int CHK_IDX_W = $clog2(SYN_W)
) (
   input  logic [SYN_W-1:0]     syn_i,
   input  logic                 word_ok_i,
   output err_class_e           cls_o,
   output logic [CHK_IDX_W-1:0] chk_idx_o
);

   localparam int CNT_W = $clog2(SYN_W + 1);

   logic [CNT_W-1:0]     ones;
   logic                 odd_weight;
   logic [CHK_IDX_W-1:0] chk_raw;

   always_comb begin
      ones = '0;
      for (int i = 0; i < SYN_W; i++) begin
         ones = ones + CNT_W'(syn_i[i]);
      end
   end

   assign odd_weight = ^syn_i;

   always_comb begin
      if (syn_i == '0) begin
         cls_o = ERR_NONE;
      end else if (ones == CNT_W'(1)) begin
         cls_o = ERR_CHECK;
      end else if (odd_weight) begin
         cls_o = word_ok_i ? ERR_SINGLE : ERR_BADCODE;
      end else begin
         cls_o = ERR_MULTI;
      end
   end

   // Check bits are numbered from the syndrome MSB downward.
   always_comb begin
      chk_raw = '0;
      for (int i = 0; i < SYN_W; i++) begin
         if (syn_i[i]) begin
            chk_raw = CHK_IDX_W'(SYN_W - 1 - i);
         end
      end
   end

   assign chk_idx_o = (cls_o == ERR_CHECK) ? chk_raw : '0;

endmodule

// File: rtl/syn_locate.sv
module syn_locate
   import secded_pkg::*;
#(
   parameter int SYN_W       = 8,
   parameter int WORD_IDX_W  = 2,
   parameter int BIT_IDX_W   = 4,
   parameter int WORD_LSB    = 1,
   parameter int BIT_LSB     = 4,
   parameter int LOOKUP_IMPL = 0
) (
   input  logic [SYN_W-1:0]      syn_i,
   output logic                  word_ok_o,
   output logic [WORD_IDX_W-1:0] word_o,
   output logic [BIT_IDX_W-1:0]  bit_o
);

   logic [WORD_CODE_W-1:0] code;
   assign code = syn_i[WORD_LSB +: WORD_CODE_W];

   generate
      if (LOOKUP_IMPL == 0) begin : g_table
         always_comb begin
            word_ok_o = 1'b1;
            word_o    = '0;
            case (code)
               3'd3:    word_o = WORD_IDX_W'(0);
               3'd5:    word_o = WORD_IDX_W'(1);
               3'd6:    word_o = WORD_IDX_W'(2);
               3'd7:    word_o = WORD_IDX_W'(3);
               default: word_ok_o = 1'b0;
            endcase
         end
      end else begin : g_logic
         // Valid codes have at least two of three bits set.
         assign word_ok_o = (code[2] & code[1]) | (code[2] & code[0]) |
                            (code[1] & code[0]);
         assign word_o    = {code[2] & code[1], code[2] & code[0]};
      end
   endgenerate

   generate
      for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_rev
         assign bit_o[BIT_IDX_W-1-k] = syn_i[BIT_LSB + k];
      end
   endgenerate

endmodule

// File: rtl/quad_bit_flip.sv
module quad_bit_flip #(
   parameter int WORD_W     = 16,
   parameter int NUM_WORDS  = 4,
   parameter int WORD_IDX_W = $clog2(NUM_WORDS),
   parameter int BIT_IDX_W  = $clog2(WORD_W),
   parameter int DATA_W     = WORD_W * NUM_WORDS
) (
   input  logic [DATA_W-1:0]     data_i,
   input  logic                  en_i,
   input  logic [WORD_IDX_W-1:0] word_i,
   input  logic [BIT_IDX_W-1:0]  bit_i,
   output logic [DATA_W-1:0]     data_o
);

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic word_hit;
         assign word_hit = en_i && (word_i == WORD_IDX_W'(w));
         for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            localparam int POS = DATA_W - 1 - (w * WORD_W + b);
            assign data_o[POS] = data_i[POS] ^
                                 (word_hit && (bit_i == BIT_IDX_W'(b)));
         end
      end
   endgenerate

endmodule

// File: rtl/secded_quad_fix.sv
module secded_quad_fix
   import secded_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int NUM_WORDS   = 4,
   parameter int SYN_W       = 8,
   parameter int LOOKUP_IMPL = 0,
   localparam int DATA_W     = WORD_W * NUM_WORDS,
   localparam int WORD_IDX_W = $clog2(NUM_WORDS),
   localparam int BIT_IDX_W  = $clog2(WORD_W),
   localparam int CHK_IDX_W  = $clog2(SYN_W)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  chk_valid,
   input  logic [SYN_W-1:0]      chk_syn,
   input  logic [DATA_W-1:0]     chk_data,
   output logic                  res_valid,
   output logic [CLASS_W-1:0]    res_class,
   output logic [CHK_IDX_W-1:0]  res_chk_idx,
   output logic [WORD_IDX_W-1:0] res_word_idx,
   output logic [BIT_IDX_W-1:0]  res_bit_idx,
   output logic [DATA_W-1:0]     res_data
);

   localparam int WORD_LSB = 1;
   localparam int BIT_LSB  = WORD_LSB + WORD_CODE_W;

   generate
      if ((1 << BIT_IDX_W) != WORD_W) begin : g_bad_word_w
         $error("WORD_W must be a power of two");
      end
      if (NUM_WORDS != 4) begin : g_bad_words
         $error("word lookup decodes exactly four words");
      end
      if (SYN_W != BIT_LSB + BIT_IDX_W) begin : g_bad_syn
         $error("SYN_W must cover parity, word code and bit nibble");
      end
      if (LOOKUP_IMPL != 0 && LOOKUP_IMPL != 1) begin : g_bad_impl
         $error("LOOKUP_IMPL must be 0 or 1");
      end
   endgenerate

   err_class_e            cls_c;
   logic                  word_ok_c;
   logic [WORD_IDX_W-1:0] word_c;
   logic [BIT_IDX_W-1:0]  bit_c;
   logic [CHK_IDX_W-1:0]  chk_c;
   logic [DATA_W-1:0]     fixed_c;
   logic                  fix_en_c;

   syn_locate #(
      .SYN_W       (SYN_W),
      .WORD_IDX_W  (WORD_IDX_W),
      .BIT_IDX_W   (BIT_IDX_W),
      .WORD_LSB    (WORD_LSB),
      .BIT_LSB     (BIT_LSB),
      .LOOKUP_IMPL (LOOKUP_IMPL)
   ) u_locate (
      .syn_i     (chk_syn),
      .word_ok_o (word_ok_c),
      .word_o    (word_c),
      .bit_o     (bit_c)
   );

   syn_classify #(
      .SYN_W     (SYN_W),
      .CHK_IDX_W (CHK_IDX_W)
   ) u_classify (
      .syn_i     (chk_syn),
      .word_ok_i (word_ok_c),
      .cls_o     (cls_c),
      .chk_idx_o (chk_c)
   );

   assign fix_en_c = (cls_c == ERR_SINGLE);

   quad_bit_flip #(
      .WORD_W    (WORD_W),
      .NUM_WORDS (NUM_WORDS)
   ) u_flip (
      .data_i (chk_data),
      .en_i   (fix_en_c),
      .word_i (word_c),
      .bit_i  (bit_c),
      .data_o (fixed_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid    <= 1'b0;
         res_class    <= ERR_NONE;
         res_chk_idx  <= '0;
         res_word_idx <= '0;
         res_bit_idx  <= '0;
         res_data     <= '0;
      end else begin
         res_valid <= chk_valid;
         if (chk_valid) begin
            res_class    <= cls_c;
            res_chk_idx  <= chk_c;
            res_word_idx <= fix_en_c ? word_c : '0;
            res_bit_idx  <= fix_en_c ? bit_c : '0;
            res_data     <= fixed_c;
         end
      end
   end

endmodule

// File: rtl/secded_quad_fix_chk.sv
module secded_quad_fix_chk #(
   parameter int SYN_W      = 8,
   parameter int DATA_W     = 64,
   parameter int CHK_IDX_W  = 3,
   parameter int WORD_IDX_W = 2,
   parameter int BIT_IDX_W  = 4
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  chk_valid,
   input logic [SYN_W-1:0]      chk_syn,
   input logic [DATA_W-1:0]     chk_data,
   input logic                  res_valid,
   input logic [2:0]            res_class,
   input logic [CHK_IDX_W-1:0]  res_chk_idx,
   input logic [WORD_IDX_W-1:0] res_word_idx,
   input logic [BIT_IDX_W-1:0]  res_bit_idx,
   input logic [DATA_W-1:0]     res_data
);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      chk_valid |=> res_valid);

   // R2
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !chk_valid |=> !res_valid);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !chk_valid |=> ($stable(res_data) && $stable(res_class) &&
                      $stable(res_word_idx) && $stable(res_bit_idx)));

   // R3
   zero_none_chk: assert property (@(posedge clk) disable iff (rst)
      (chk_valid && chk_syn == '0) |=> (res_class == 3'd0));

   // R4
   check_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      chk_valid |=> ((res_class != 3'd1) || ($countones($past(chk_syn)) == 1)));

   // R7
   single_flip_chk: assert property (@(posedge clk) disable iff (rst)
      chk_valid |=> ((res_class != 3'd2) ||
                     ($countones(res_data ^ $past(chk_data)) == 1)));

   // R8
   pass_through_chk: assert property (@(posedge clk) disable iff (rst)
      chk_valid |=> ((res_class == 3'd2) || (res_data == $past(chk_data))));

   // R9
   multi_even_chk: assert property (@(posedge clk) disable iff (rst)
      chk_valid |=> ((res_class != 3'd4) ||
                     (($countones($past(chk_syn)) % 2 == 0) && ($past(chk_syn) != '0))));

   // R10
   idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (((res_class == 3'd1) || (res_chk_idx == '0)) &&
                     ((res_class == 3'd2) || (res_word_idx == '0 && res_bit_idx == '0))));

   // R1
   class_range_chk: assert property (@(posedge clk) disable iff (rst)
      res_class <= 3'd4);

endmodule

bind secded_quad_fix secded_quad_fix_chk #(
   .SYN_W      (SYN_W),
   .DATA_W     (DATA_W),
   .CHK_IDX_W  (CHK_IDX_W),
   .WORD_IDX_W (WORD_IDX_W),
   .BIT_IDX_W  (BIT_IDX_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .chk_valid    (chk_valid),
   .chk_syn      (chk_syn),
   .chk_data     (chk_data),
   .res_valid    (res_valid),
   .res_class    (res_class),
   .res_chk_idx  (res_chk_idx),
   .res_word_idx (res_word_idx),
   .res_bit_idx  (res_bit_idx),
   .res_data     (res_data)
);

// File: tb/tb_secded_quad_fix.sv
module tb_secded_quad_fix;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        chk_valid = 1'b0;
   logic [7:0]  chk_syn = '0;
   logic [63:0] chk_data = '0;
   logic        res_valid;
   logic [2:0]  res_class;
   logic [2:0]  res_chk_idx;
   logic [1:0]  res_word_idx;
   logic [3:0]  res_bit_idx;
   logic [63:0] res_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   secded_quad_fix dut (
      .clk          (clk),
      .rst          (rst),
      .chk_valid    (chk_valid),
      .chk_syn      (chk_syn),
      .chk_data     (chk_data),
      .res_valid    (res_valid),
      .res_class    (res_class),
      .res_chk_idx  (res_chk_idx),
      .res_word_idx (res_word_idx),
      .res_bit_idx  (res_bit_idx),
      .res_data     (res_data)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int weight(input logic [7:0] s);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(s[i]);
      return n;
   endfunction

   function automatic int exp_word(input logic [7:0] s);
      case (s[3:1])
         3'd3: return 0;
         3'd5: return 1;
         3'd6: return 2;
         3'd7: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic int exp_class(input logic [7:0] s);
      if (s == 8'd0) return 0;
      if (weight(s) == 1) return 1;
      if (weight(s) % 2 == 1) return (exp_word(s) >= 0) ? 2 : 3;
      return 4;
   endfunction

   function automatic int exp_chk(input logic [7:0] s);
      for (int i = 0; i < 8; i++) if (s == 8'(1 << i)) return 7 - i;
      return 0;
   endfunction

   function automatic int exp_bit(input logic [7:0] s);
      return 8 * int'(s[4]) + 4 * int'(s[5]) + 2 * int'(s[6]) + int'(s[7]);
   endfunction

   task automatic apply_and_check(input logic [7:0] s, input logic [63:0] d);
      int cls;
      int w;
      int b;
      logic [63:0] ed;
      string ctag;
      chk_valid = 1'b1;
      chk_syn   = s;
      chk_data  = d;
      @(negedge clk);
      cls = exp_class(s);
      w   = (cls == 2) ? exp_word(s) : 0;
      b   = (cls == 2) ? exp_bit(s) : 0;
      ed  = (cls == 2) ? (d ^ (64'd1 << (63 - (16 * w + b)))) : d;
      case (cls)
         0: ctag = "R3";
         1: ctag = "R4";
         2: ctag = "R5";
         3: ctag = "R8";
         default: ctag = "R9";
      endcase
      check(res_valid == 1'b1, "R2 valid", 64'(res_valid), 64'd1);
      check(int'(res_class) == cls, {ctag, " class"}, 64'(res_class), 64'(cls));
      check(int'(res_chk_idx) == exp_chk(s) || cls != 1, "R4 chk_idx",
            64'(res_chk_idx), 64'(exp_chk(s)));
      check(res_chk_idx == 3'd0 || cls == 1, "R10 chk_idx", 64'(res_chk_idx), 64'd0);
      check(int'(res_word_idx) == w, (cls == 2) ? "R5 word" : "R10 word",
            64'(res_word_idx), 64'(w));
      check(int'(res_bit_idx) == b, (cls == 2) ? "R6 bit" : "R10 bit",
            64'(res_bit_idx), 64'(b));
      check(res_data == ed, (cls == 2) ? "R7 data" : {ctag, " data"}, res_data, ed);
   endtask

   initial begin
      logic [63:0] pats [4];
      logic [63:0] held;
      pats[0] = 64'h0000_0000_0000_0000;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h0123_4567_89AB_CDEF;
      pats[3] = 64'hA5A5_5A5A_F00F_0FF0;

      chk_valid = 1'b1;
      chk_syn   = 8'h37;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(res_valid == 1'b0, "R1 valid", 64'(res_valid), 64'd0);
      check(res_class == 3'd0, "R1 class", 64'(res_class), 64'd0);
      rst = 1'b0;
      chk_valid = 1'b0;
      @(negedge clk);
      check(res_valid == 1'b0, "R2 idle valid", 64'(res_valid), 64'd0);

      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 256; s++) begin
            apply_and_check(8'(s), pats[p]);
         end
      end

      // R2 hold while idle
      apply_and_check(8'h3B, pats[2]);
      held = res_data;
      chk_valid = 1'b0;
      chk_syn   = 8'h00;
      chk_data  = pats[3];
      @(negedge clk);
      check(res_valid == 1'b0, "R2 drop", 64'(res_valid), 64'd0);
      check(res_data == held, "R2 hold data", res_data, held);
      check(res_class == 3'd2, "R2 hold class", 64'(res_class), 64'd2);

      // R1 reset mid-run
      apply_and_check(8'hFF, pats[1]);
      rst = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R1 mid valid", 64'(res_valid), 64'd0);
      check(res_class == 3'd0, "R1 mid class", 64'(res_class), 64'd0);
      rst = 1'b0;
      chk_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule